// File: doc/BRIEF.md
# Triggered Block Transfer Engine

This block is a memory-mapped controller that copies a buffer of cells between main memory and one selected device channel. Software programs a small register window: a channel number, a length in cells and a start pointer split over several cells. It then touches the trigger cell. A write to the trigger sends memory contents out to the device. A read from the trigger brings device words in and stores them in memory.

The engine drives a simple word memory port and walks the buffer one cell at a time in ascending order. It exchanges data with devices over two valid/ready word streams, one for each direction. Any command detail a device needs, such as a sector or a name, travels inside the buffer. The window base sits just past the video area of the upper half of the address space. It is derived from the address width and the screen parameters.

Top module: `blk_xfer_engine`

## Requirements
- R1: With default parameters the window base is 0x8013. The channel cell is at 0x8013, the length cell at 0x8014 and the pointer cells at 0x8015 and 0x8016. Each of these cells reads back the last value written to it. The acknowledge follows one cycle after the request, and the read data is valid while the acknowledge is high.
- R2: The pointer is formed with the lowest-addressed pointer cell as the most significant part. With defaults, a value hi at 0x8015 and lo at 0x8016 give a start address of {hi, lo}.
- R3: A write to the trigger cell (0x8017 by default) reads memory from the start address upward, one cell per granted request. Each read word appears on the outgoing device stream in order.
- R4: A read of the trigger cell takes each word accepted from the incoming device stream and writes it to memory, from the start address upward, one cell per granted request.
- R5: The CPU access to the trigger cell gets no acknowledge until the last cell has completed its handshake. The acknowledge then comes while the engine drives no memory or device request.
- R6: A length of zero acknowledges the trigger with no memory request and no device handshake.
- R7: A memory request keeps its address, data and direction until it is granted. An outgoing device word keeps its value until it is accepted. A stall on either side loses and repeats no word.
- R8: The channel output always shows the value held in the channel cell.
- R9: An access outside the five-cell window gets no acknowledge and changes no cell.
- R10: Every acknowledge lasts exactly one cycle.
- R11: The read data returned with the acknowledge of a trigger read is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpu_req_i | input | 1 | CPU access request, held until acknowledge |
| cpu_we_i | input | 1 | CPU access is a write |
| cpu_addr_i | input | ADDR_W | CPU cell address |
| cpu_wdata_i | input | DATA_W | CPU write data |
| cpu_rdata_o | output | DATA_W | CPU read data, valid with acknowledge |
| cpu_ack_o | output | 1 | One-cycle access acknowledge |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Memory request is a write |
| mem_addr_o | output | ADDR_W | Memory cell address |
| mem_wdata_o | output | DATA_W | Memory write data |
| mem_rdata_i | input | DATA_W | Memory read data, valid with grant |
| mem_gnt_i | input | 1 | Memory grant, completes a request |
| port_o | output | DATA_W | Selected device channel |
| dev_in_valid_i | input | 1 | Incoming device word valid |
| dev_in_data_i | input | DATA_W | Incoming device word |
| dev_in_ready_o | output | 1 | Engine accepts incoming word |
| dev_out_valid_o | output | 1 | Outgoing device word valid |
| dev_out_data_o | output | DATA_W | Outgoing device word |
| dev_out_ready_i | input | 1 | Device accepts outgoing word |

## Verification
Two events can fall in the same cycle: the device offers a new word while the memory write of the previous word is still waiting for its grant, and, in the outgoing direction, a memory grant pattern that does not line up with the device ready pattern. The bench provokes both by masking the grant and the ready with unrelated cycle patterns while the source keeps its valid high. A scoreboard queue holds every expected memory write (address and data) and every expected outgoing word. Each handshake pops and compares one entry, so a lost, repeated or misplaced word shows up as a mismatch or as a queue that is not empty when the trigger is acknowledged.

// File: rtl/blk_xfer_pkg.sv
package blk_xfer_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_IN_WAIT,
    ST_IN_MEM,
    ST_OUT_MEM,
    ST_OUT_DEV,
    ST_DONE
  } xfer_state_e;

  // Window base: start of upper half, past three video cells and the frame
  function automatic longint unsigned blk_base(int aw, int w, int h, int c);
    return (longint'(1) << (aw - 1)) + 3 + longint'(w) * h * c;
  endfunction
endpackage

// File: rtl/blk_xfer_regs.sv
module blk_xfer_regs #(
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned ADDR_W     = 16,
  parameter int unsigned ADDR_CELLS = 2,
  parameter logic [ADDR_W-1:0] BASE = '0,
  localparam int unsigned PTR_W     = ADDR_CELLS * DATA_W,
  localparam int unsigned TRIG_OFF  = 2 + ADDR_CELLS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cpu_req_i,
  input  logic              cpu_we_i,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  input  logic [DATA_W-1:0] cpu_wdata_i,
  output logic              reg_ack_o,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              trig_o,
  output logic [DATA_W-1:0] port_o,
  output logic [DATA_W-1:0] size_o,
  output logic [PTR_W-1:0]  ptr_o
);
  logic [ADDR_W-1:0] off;
  logic              hit;
  logic              acc;
  logic [DATA_W-1:0] port_q, size_q;
  logic [DATA_W-1:0] addr_q [ADDR_CELLS];

  assign off    = cpu_addr_i - BASE;
  assign hit    = off < ADDR_W'(TRIG_OFF);
  assign trig_o = cpu_req_i && (off == ADDR_W'(TRIG_OFF));
  assign acc    = cpu_req_i && hit && !reg_ack_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      port_q      <= '0;
      size_q      <= '0;
      reg_ack_o   <= 1'b0;
      reg_rdata_o <= '0;
    end else begin
      reg_ack_o <= acc;
      if (acc && cpu_we_i && off == ADDR_W'(0)) port_q <= cpu_wdata_i;
      if (acc && cpu_we_i && off == ADDR_W'(1)) size_q <= cpu_wdata_i;
      if (acc) begin
        if (off == ADDR_W'(0))      reg_rdata_o <= port_q;
        else if (off == ADDR_W'(1)) reg_rdata_o <= size_q;
        else                        reg_rdata_o <= addr_q[off - ADDR_W'(2)];
      end
    end
  end

  for (genvar i = 0; i < ADDR_CELLS; i++) begin : g_ptr
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) addr_q[i] <= '0;
      else if (acc && cpu_we_i && off == ADDR_W'(2 + i)) addr_q[i] <= cpu_wdata_i;
    end
    // lowest-addressed cell is most significant
    assign ptr_o[(ADDR_CELLS-1-i)*DATA_W +: DATA_W] = addr_q[i];
  end

  assign port_o = port_q;
  assign size_o = size_q;
endmodule

// File: rtl/blk_xfer_seq.sv
module blk_xfer_seq
  import blk_xfer_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned PTR_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              dir_out_i,
  input  logic [DATA_W-1:0] size_i,
  input  logic [PTR_W-1:0]  ptr_i,
  output logic              done_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  input  logic              mem_gnt_i,
  input  logic              dev_in_valid_i,
  input  logic [DATA_W-1:0] dev_in_data_i,
  output logic              dev_in_ready_o,
  output logic              dev_out_valid_o,
  output logic [DATA_W-1:0] dev_out_data_o,
  input  logic              dev_out_ready_i
);
  xfer_state_e       st_q;
  logic [PTR_W-1:0]  ptr_q;
  logic [DATA_W-1:0] cnt_q, hold_q;
  logic              last;

  assign last = cnt_q == DATA_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      ptr_q  <= '0;
      cnt_q  <= '0;
      hold_q <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          ptr_q <= ptr_i;
          cnt_q <= size_i;
          if (size_i == '0) st_q <= ST_DONE;
          else              st_q <= dir_out_i ? ST_OUT_MEM : ST_IN_WAIT;
        end
        ST_IN_WAIT: if (dev_in_valid_i) begin
          hold_q <= dev_in_data_i;
          st_q   <= ST_IN_MEM;
        end
        ST_IN_MEM: if (mem_gnt_i) begin
          ptr_q <= ptr_q + PTR_W'(1);
          cnt_q <= cnt_q - DATA_W'(1);
          st_q  <= last ? ST_DONE : ST_IN_WAIT;
        end
        ST_OUT_MEM: if (mem_gnt_i) begin
          hold_q <= mem_rdata_i;
          st_q   <= ST_OUT_DEV;
        end
        ST_OUT_DEV: if (dev_out_ready_i) begin
          ptr_q <= ptr_q + PTR_W'(1);
          cnt_q <= cnt_q - DATA_W'(1);
          st_q  <= last ? ST_DONE : ST_OUT_MEM;
        end
        ST_DONE: st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign done_o          = st_q == ST_DONE;
  assign mem_req_o       = (st_q == ST_IN_MEM) || (st_q == ST_OUT_MEM);
  assign mem_we_o        = st_q == ST_IN_MEM;
  assign mem_addr_o      = ptr_q[ADDR_W-1:0];
  assign mem_wdata_o     = hold_q;
  assign dev_in_ready_o  = st_q == ST_IN_WAIT;
  assign dev_out_valid_o = st_q == ST_OUT_DEV;
  assign dev_out_data_o  = hold_q;
endmodule

// File: rtl/blk_xfer_engine.sv
module blk_xfer_engine #(
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned ADDR_W     = 16,
  parameter int unsigned ADDR_CELLS = 2,
  parameter int unsigned SCR_W      = 4,
  parameter int unsigned SCR_H      = 4,
  parameter int unsigned PIX_CELLS  = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cpu_req_i,
  input  logic              cpu_we_i,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  input  logic [DATA_W-1:0] cpu_wdata_i,
  output logic [DATA_W-1:0] cpu_rdata_o,
  output logic              cpu_ack_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  input  logic              mem_gnt_i,
  output logic [DATA_W-1:0] port_o,
  input  logic              dev_in_valid_i,
  input  logic [DATA_W-1:0] dev_in_data_i,
  output logic              dev_in_ready_o,
  output logic              dev_out_valid_o,
  output logic [DATA_W-1:0] dev_out_data_o,
  input  logic              dev_out_ready_i
);
  localparam int unsigned PTR_W = ADDR_CELLS * DATA_W;
  localparam logic [ADDR_W-1:0] BASE =
    ADDR_W'(blk_xfer_pkg::blk_base(ADDR_W, SCR_W, SCR_H, PIX_CELLS));

  logic              reg_ack, trig, xfer_done;
  logic [DATA_W-1:0] reg_rdata, size;
  logic [PTR_W-1:0]  ptr;

  blk_xfer_regs #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .ADDR_CELLS(ADDR_CELLS), .BASE(BASE)
  ) u_regs (
    .clk_i, .rst_ni, .cpu_req_i, .cpu_we_i, .cpu_addr_i, .cpu_wdata_i,
    .reg_ack_o(reg_ack), .reg_rdata_o(reg_rdata), .trig_o(trig),
    .port_o, .size_o(size), .ptr_o(ptr)
  );

  blk_xfer_seq #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .PTR_W(PTR_W)) u_seq (
    .clk_i, .rst_ni, .start_i(trig), .dir_out_i(cpu_we_i), .size_i(size),
    .ptr_i(ptr), .done_o(xfer_done), .mem_req_o, .mem_we_o, .mem_addr_o,
    .mem_wdata_o, .mem_rdata_i, .mem_gnt_i, .dev_in_valid_i, .dev_in_data_i,
    .dev_in_ready_o, .dev_out_valid_o, .dev_out_data_o, .dev_out_ready_i
  );

  assign cpu_ack_o   = reg_ack || xfer_done;
  assign cpu_rdata_o = reg_ack ? reg_rdata : '0;
endmodule

// File: rtl/blk_xfer_chk.sv
module blk_xfer_chk #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cpu_ack_o,
  input logic              mem_req_o,
  input logic              mem_we_o,
  input logic              mem_gnt_i,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [DATA_W-1:0] mem_wdata_o,
  input logic              dev_in_ready_o,
  input logic              dev_out_valid_o,
  input logic              dev_out_ready_i,
  input logic [DATA_W-1:0] dev_out_data_o
);
  logic              seen_q;
  logic [ADDR_W-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_q <= 1'b0;
      prev_q <= '0;
    end else if (cpu_ack_o) begin
      seen_q <= 1'b0;
    end else if (mem_req_o && mem_gnt_i) begin
      seen_q <= 1'b1;
      prev_q <= mem_addr_o;
    end
  end

  a_r7_mem_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_gnt_i |=> mem_req_o && $stable(mem_addr_o)
      && $stable(mem_wdata_o) && $stable(mem_we_o));

  a_r7_out_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dev_out_valid_o && !dev_out_ready_i |=> dev_out_valid_o && $stable(dev_out_data_o));

  a_r10_ack_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_ack_o |=> !cpu_ack_o);

  a_r5_ack_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_ack_o |-> !mem_req_o && !dev_out_valid_o && !dev_in_ready_o);

  a_r3_ascending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_gnt_i && seen_q |-> mem_addr_o == prev_q + ADDR_W'(1));

  a_r4_one_side: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({mem_req_o, dev_in_ready_o, dev_out_valid_o}) <= 1);
endmodule

bind blk_xfer_engine blk_xfer_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cpu_ack_o(cpu_ack_o), .mem_req_o(mem_req_o),
  .mem_we_o(mem_we_o), .mem_gnt_i(mem_gnt_i), .mem_addr_o(mem_addr_o),
  .mem_wdata_o(mem_wdata_o), .dev_in_ready_o(dev_in_ready_o),
  .dev_out_valid_o(dev_out_valid_o), .dev_out_ready_i(dev_out_ready_i),
  .dev_out_data_o(dev_out_data_o)
);

// File: tb/blk_xfer_engine_tb.sv
module blk_xfer_engine_tb;
  localparam logic [15:0] BK = 16'h8013;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        cpu_req = 1'b0, cpu_we = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0, cpu_rdata;
  logic        cpu_ack;
  logic        mem_req, mem_we, mem_gnt = 1'b0;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata, mem_rdata, port;
  logic        din_valid = 1'b0, din_ready;
  logic [7:0]  din_data = '0;
  logic        dout_valid, dout_ready = 1'b0;
  logic [7:0]  dout_data;

  int errors = 0, checks = 0, cyc = 0, mem_hs = 0, dev_hs = 0;
  int gnt_mode = 0, rdy_mode = 0;
  logic [7:0]  mem_m [4096];
  logic [7:0]  din_q [$];
  logic [7:0]  exp_out [$];
  logic [23:0] exp_wr [$];

  always #10 clk = ~clk;

  blk_xfer_engine u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cpu_req_i(cpu_req), .cpu_we_i(cpu_we),
    .cpu_addr_i(cpu_addr), .cpu_wdata_i(cpu_wdata), .cpu_rdata_o(cpu_rdata),
    .cpu_ack_o(cpu_ack), .mem_req_o(mem_req), .mem_we_o(mem_we),
    .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata),
    .mem_gnt_i(mem_gnt), .port_o(port), .dev_in_valid_i(din_valid),
    .dev_in_data_i(din_data), .dev_in_ready_o(din_ready),
    .dev_out_valid_o(dout_valid), .dev_out_data_o(dout_data),
    .dev_out_ready_i(dout_ready)
  );

  assign mem_rdata = mem_m[mem_addr[11:0]];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // Memory model, device source and scoreboard monitor
  always begin
    @(negedge clk);
    cyc++;
    mem_gnt    = (gnt_mode == 0) ? 1'b1 : (cyc % 3 != 1);
    dout_ready = (rdy_mode == 0) ? 1'b1 : (cyc % 4 == 2);
    din_valid  = din_q.size() > 0;
    din_data   = din_valid ? din_q[0] : 8'h00;
    #1;
    if (mem_req && mem_gnt) begin
      mem_hs++;
      if (mem_we) begin
        mem_m[mem_addr[11:0]] = mem_wdata;
        if (exp_wr.size() == 0) chk("R4 unexpected write", {mem_addr, mem_wdata}, 24'hxxxxxx);
        else chk("R4 memory write addr/data", {mem_addr, mem_wdata}, exp_wr.pop_front());
      end
    end
    if (dout_valid && dout_ready) begin
      dev_hs++;
      if (exp_out.size() == 0) chk("R3 unexpected word", {24'h0, dout_data}, 32'hxxxxxxxx);
      else chk("R3 outgoing word", {24'h0, dout_data}, {24'h0, exp_out.pop_front()});
    end
    if (din_valid && din_ready) begin
      dev_hs++;
      void'(din_q.pop_front());
    end
  end

  // Watchdog
  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  task automatic cpu_acc(input logic we, input logic [15:0] a, input logic [7:0] d,
                         input int max_wait, output logic [7:0] rd, output logic got);
    int w;
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
    got = 1'b0; rd = '0; w = 0;
    while (!got && w < max_wait) begin
      @(negedge clk);
      w++;
      if (cpu_ack) begin got = 1'b1; rd = cpu_rdata; end
    end
    cpu_req = 1'b0;
    if (got) begin
      @(negedge clk);
      chk("R10 ack single cycle", {31'h0, cpu_ack}, 32'h0);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d, input string tag);
    logic [7:0] rd; logic got;
    cpu_acc(1'b1, a, d, 8, rd, got);
    chk(tag, {31'h0, got}, 32'h1);
  endtask

  task automatic rd_chk(input logic [15:0] a, input logic [7:0] e, input string tag);
    logic [7:0] rd; logic got;
    cpu_acc(1'b0, a, 8'h00, 8, rd, got);
    chk(tag, {23'h0, got, rd}, {23'h0, 1'b1, e});
  endtask

  task automatic setup(input logic [7:0] n, input logic [15:0] p);
    wr(BK + 16'd1, n, "R1 length write ack");
    wr(BK + 16'd2, p[15:8], "R2 pointer hi write ack");
    wr(BK + 16'd3, p[7:0], "R2 pointer lo write ack");
  endtask

  task automatic run_out(input logic [7:0] n, input logic [15:0] p, input string tag);
    logic [7:0] rd; logic got;
    setup(n, p);
    for (int i = 0; i < n; i++) begin
      mem_m[12'(p + 16'(i))] = 8'(8'h3C ^ (p[7:0] + 8'(i)) ^ {p[11:8], 4'h0});
      exp_out.push_back(mem_m[12'(p + 16'(i))]);
    end
    cpu_acc(1'b1, BK + 16'd4, 8'h00, 2000, rd, got);
    chk({tag, " R5 trigger acknowledged"}, {31'h0, got}, 32'h1);
    chk({tag, " R5 all words out before ack"}, exp_out.size(), 0);
    exp_out.delete();
  endtask

  task automatic run_in(input logic [7:0] n, input logic [15:0] p, input string tag);
    logic [7:0] rd; logic got; logic [7:0] v;
    setup(n, p);
    for (int i = 0; i < n; i++) begin
      v = 8'(8'hA1 + 8'(i * 7) + p[7:0]);
      din_q.push_back(v);
      exp_wr.push_back({p + 16'(i), v});
    end
    cpu_acc(1'b0, BK + 16'd4, 8'h00, 2000, rd, got);
    chk({tag, " R5 trigger acknowledged"}, {31'h0, got}, 32'h1);
    chk({tag, " R11 trigger read data"}, {24'h0, rd}, 32'h0);
    chk({tag, " R4 all writes done before ack"}, exp_wr.size(), 0);
    chk({tag, " R4 source drained"}, din_q.size(), 0);
    exp_wr.delete(); din_q.delete();
  endtask

  initial begin
    logic [7:0] rd; logic got; int hs0, dh0;
    for (int i = 0; i < 4096; i++) mem_m[i] = 8'h00;
    repeat (3) @(negedge clk);
    chk("reset ack low", {31'h0, cpu_ack}, 32'h0);
    chk("reset mem_req low", {31'h0, mem_req}, 32'h0);
    chk("reset out valid low", {31'h0, dout_valid}, 32'h0);
    chk("reset in ready low", {31'h0, din_ready}, 32'h0);
    chk("R8 reset channel", {24'h0, port}, 32'h0);
    rst_n = 1'b1;

    // R1/R8: window placement and read-back
    wr(BK, 8'h5A, "R1 channel write ack");
    chk("R8 channel output", {24'h0, port}, 32'h5A);
    setup(8'd4, 16'h0120);
    rd_chk(BK, 8'h5A, "R1 channel read-back");
    rd_chk(BK + 16'd1, 8'd4, "R1 length read-back");
    rd_chk(BK + 16'd2, 8'h01, "R1 pointer hi read-back");
    rd_chk(BK + 16'd3, 8'h20, "R1 pointer lo read-back");

    // R3/R2: outgoing transfers, unstalled then stalled
    run_out(8'd4, 16'h0120, "out plain");
    run_out(8'd2, 16'h0FF0, "R2 out pointer order");
    gnt_mode = 1; rdy_mode = 1;
    run_out(8'd7, 16'h0345, "R7 out stalled");

    // R4: incoming, then with memory stalls against a waiting source
    gnt_mode = 0; rdy_mode = 0;
    run_in(8'd3, 16'h0200, "in plain");
    gnt_mode = 1;
    run_in(8'd9, 16'h02FC, "R7 in stalled");
    gnt_mode = 0;
    chk("R4 memory after input", {24'h0, mem_m[12'h200]}, {24'h0, 8'hA1});

    // R6: zero length
    hs0 = mem_hs; dh0 = dev_hs;
    din_q.push_back(8'h77);
    setup(8'd0, 16'h0400);
    cpu_acc(1'b0, BK + 16'd4, 8'h00, 20, rd, got);
    chk("R6 zero length ack", {31'h0, got}, 32'h1);
    chk("R6 no memory traffic", mem_hs - hs0, 0);
    chk("R6 no device handshake", dev_hs - dh0, 0);
    din_q.delete();
    @(negedge clk);
    cpu_acc(1'b1, BK + 16'd4, 8'h00, 20, rd, got);
    chk("R6 zero length out ack", {31'h0, got}, 32'h1);
    chk("R6 no traffic out", mem_hs - hs0 + dev_hs - dh0, 0);

    // R9: outside the window
    cpu_acc(1'b1, BK - 16'd1, 8'hEE, 6, rd, got);
    chk("R9 below window no ack", {31'h0, got}, 32'h0);
    cpu_acc(1'b1, BK + 16'd5, 8'hEE, 6, rd, got);
    chk("R9 above window no ack", {31'h0, got}, 32'h0);
    rd_chk(BK, 8'h5A, "R9 channel unchanged");
    chk("R9 channel output unchanged", {24'h0, port}, 32'h5A);

    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule